// File: doc/BRIEF.md
# Decoder Input Word Queue with Underrun Fill

This block holds received CVSD words on their way into a decoder core. A producer (processor or DMA engine) pushes 16-bit words in; the decoder pulls one word per decode interval, which is nominally every 250 µs. The block reports how many words it holds. It raises a low-water flag and an empty flag, and it combines them into one interrupt line under two separate enables. It also pulses a DMA request each time the core pulls a word.

When the core pulls from an empty queue, the block does not hand over stale data. It returns a fixed alternating-bit word, 16'hAAAA. The decoder then walks up and down in small steps instead of drifting, which keeps the audible distortion from a late producer low. A push into a full queue is discarded. That event is remembered in a sticky flag until the status is read.

Top module: `dec_in_fifo`

## Requirements
- R1: The queue holds up to 8 words of 16 bits. Words leave on `pop_data` in the order they were written, including across pointer wrap-around.
- R2: `level` gives the number of stored words (0 to 8). It takes its new value at the clock edge that accepts the write or pop.
- R3: `near_empty` is 1 whenever `level` is 3 or less, including 0.
- R4: `empty` is 1 exactly when `level` is 0.
- R5: A `pop` while `empty` is 1 makes `pop_data` equal 16'hAAAA after that edge. It leaves `level` unchanged unless a write is accepted in the same cycle.
- R6: A write and a pop in the same cycle on a non-empty queue return the oldest word and store the new one, so `level` stays the same.
- R7: A write while `level` is 8 is discarded, even with a simultaneous pop, and sets `ovf_flag`. `ovf_flag` stays 1 until a cycle with `stat_rd` high. When a discard and `stat_rd` happen together, the set wins.
- R8: `irq` equals (`ne_irq_en` AND `near_empty`) OR (`err_irq_en` AND `empty`), and follows enable changes in the same cycle.
- R9: With `dma_en` high, every pop, underrun pops included, gives a one-cycle `dma_req` pulse in the cycle after the pop. With `dma_en` low, `dma_req` stays 0.
- R10: After reset, `level` is 0, `empty` and `near_empty` are 1, and `ovf_flag`, `dma_req` and `pop_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 16 | Word to store |
| stat_rd | input | 1 | Status read strobe, clears `ovf_flag` |
| pop | input | 1 | Decoder core pull strobe |
| ne_irq_en | input | 1 | Enables `near_empty` onto `irq` |
| err_irq_en | input | 1 | Enables `empty` onto `irq` |
| dma_en | input | 1 | Enables `dma_req` pulses |
| pop_data | output | 16 | Word returned by the last pop |
| level | output | 4 | Stored word count |
| near_empty | output | 1 | Low-water flag |
| empty | output | 1 | Empty flag |
| ovf_flag | output | 1 | Sticky discarded-write flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Per-pop DMA request pulse |

## Verification
Each register-backed result is due at the first clock edge after the stimulus: `pop_data`, `level`, `empty`, `near_empty`, `ovf_flag` and `dma_req`. `irq` also depends directly on the enable inputs, so it settles within the same cycle. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It samples a quarter period after that edge, so every comparison sees the state from that one edge and nothing later. Enable-only changes to `irq` are sampled before any further edge.

// File: rtl/dec_in_fifo.sv
module dec_in_fifo #(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 8,
  parameter int NE_LEVEL = 3,
  parameter logic [WIDTH-1:0] FILL = 16'hAAAA
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WIDTH-1:0]             wr_data,
  input  logic                         stat_rd,
  input  logic                         pop,
  input  logic                         ne_irq_en,
  input  logic                         err_irq_en,
  input  logic                         dma_en,
  output logic [WIDTH-1:0]             pop_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         near_empty,
  output logic                         empty,
  output logic                         ovf_flag,
  output logic                         irq,
  output logic                         dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;

  wire full    = (count == CW'(DEPTH));
  wire do_wr   = wr_en && !full;
  wire do_rd   = pop && (count != '0);

  assign level      = count;
  assign empty      = (count == '0);
  assign near_empty = (count <= CW'(NE_LEVEL));
  assign irq        = (ne_irq_en && near_empty) || (err_irq_en && empty);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      pop_data <= '0;
      ovf_flag <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (pop) pop_data <= do_rd ? mem[rd_ptr] : FILL;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full)  ovf_flag <= 1'b1;
      else if (stat_rd)   ovf_flag <= 1'b0;
      dma_req <= pop && dma_en;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> near_empty); // R3
  AST_UNDERRUN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (pop_data == FILL)); // R5
  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !wr_en) |=> empty); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !pop) |=> (full && ovf_flag)); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(wr_en && full)) |=> !ovf_flag); // R7
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && dma_en) |=> dma_req); // R9
  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && dma_en) |=> !dma_req); // R9
endmodule

// File: tb/tb_dec_in_fifo.sv
module tb_dec_in_fifo;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, stat_rd = 0, pop = 0;
  logic ne_irq_en = 0, err_irq_en = 0, dma_en = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] pop_data;
  logic [3:0]  level;
  logic near_empty, empty, ovf_flag, irq, dma_req;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dec_in_fifo dut (.clk, .rst_n, .wr_en, .wr_data, .stat_rd, .pop,
    .ne_irq_en, .err_irq_en, .dma_en, .pop_data, .level, .near_empty,
    .empty, .ovf_flag, .irq, .dma_req);

  // {wr, wdata, pop, check_data, exp_data, exp_level}
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'h1111, 1'b0, 1'b0, 16'h0000, 4'd1},
    {1'b1, 16'h2222, 1'b0, 1'b0, 16'h0000, 4'd2},
    {1'b1, 16'h3333, 1'b0, 1'b0, 16'h0000, 4'd3},
    {1'b1, 16'h4444, 1'b0, 1'b0, 16'h0000, 4'd4},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h1111, 4'd3},
    {1'b1, 16'h5555, 1'b1, 1'b1, 16'h2222, 4'd3},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h3333, 4'd2},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h4444, 4'd1},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h5555, 4'd0},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'hAAAA, 4'd0},
    {1'b1, 16'h6666, 1'b1, 1'b1, 16'hAAAA, 4'd1},
    {1'b0, 16'h0000, 1'b1, 1'b1, 16'h6666, 4'd0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [15:0] d, logic p, logic s);
    @(negedge clk);
    wr_en = w; wr_data = d; pop = p; stat_rd = s;
    @(posedge clk);
    #5;
    wr_en = 0; pop = 0; stat_rd = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R10 level", level, 0);
    chk("R10 flags", {empty, near_empty, ovf_flag, dma_req}, 4'b1100);
    chk("R10 pop_data", pop_data, 16'h0);
    @(negedge clk); rst_n = 1;
    dma_en = 1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][38], VEC[i][37:22], VEC[i][21], 1'b0);
      chk("R2 level", level, VEC[i][3:0]);
      chk("R3/R4 flags", {near_empty, empty},
          {VEC[i][3:0] <= 4'd3, VEC[i][3:0] == 4'd0});
      chk("R9 dma_req", dma_req, VEC[i][21]);
      if (VEC[i][20]) chk("R1/R5/R6 pop_data", pop_data, VEC[i][19:4]);
    end

    // R9 quiet when disabled
    dma_en = 0;
    step(0, 0, 1, 0);
    chk("R9 no dma when disabled", dma_req, 0);
    chk("R5 underrun fill", pop_data, 16'hAAAA);

    // fill to 8 across the wrap point, R3 boundary at 4
    for (int i = 0; i < 8; i++) begin
      step(1, 16'hB000 + 16'(i), 0, 0);
      if (i == 2) chk("R3 near_empty at 3", near_empty, 1);
      if (i == 3) chk("R3 near_empty clear at 4", near_empty, 0);
    end
    chk("R2 full level", level, 8);
    step(1, 16'hDEAD, 0, 0);
    chk("R7 drop keeps level", level, 8);
    chk("R7 ovf set", ovf_flag, 1);
    step(0, 0, 0, 0);
    chk("R7 ovf sticky", ovf_flag, 1);
    step(1, 16'hBEEF, 0, 1);
    chk("R7 set wins over read", ovf_flag, 1);
    step(0, 0, 0, 1);
    chk("R7 ovf cleared", ovf_flag, 0);
    step(1, 16'hC0DE, 1, 0);
    chk("R7 drop with pop level", level, 7);
    chk("R7 drop with pop data", pop_data, 16'hB000);
    for (int i = 1; i < 8; i++) begin
      step(0, 0, 1, 0);
      chk("R1 order after wrap", pop_data, 16'hB000 + 16'(i));
    end

    // R8 interrupt combination
    chk("R8 irq off", irq, 0);
    err_irq_en = 1; #1;
    chk("R8 irq from empty", irq, 1);
    err_irq_en = 0; ne_irq_en = 1; #1;
    chk("R8 irq from near_empty", irq, 1);
    for (int i = 0; i < 4; i++) step(1, 16'h0F0F, 0, 0);
    chk("R8 irq clears at 4", irq, 0);
    err_irq_en = 1; #1;
    chk("R8 err enable no effect when not empty", irq, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule